// File: doc/BRIEF.md
# Chien Search Error Locator

This block finds the error positions of one stored sector once an error-locator polynomial sigma(x) is known. After a start pulse it takes the sigma coefficients, the declared polynomial degree, a sector-size select and a count of spare bytes. It then tries every candidate bit position of the codeword in turn, one position per clock. Each position where sigma evaluates to zero is stored in a short position list. At the end of the sweep the block compares the number of roots found with the declared degree. If they are equal the sector can be corrected. If they differ the sector is flagged uncorrectable.

The codeword covers the sector data bits plus m·T parity bits. T is the correction capability. The field width m is 13 for the small sector size and 14 for the large one. For each listed position the block also gives the byte index and bit index of the bit to flip. A per-entry enable is raised only when that byte lies within the data bytes plus the allowed spare bytes. Finding sigma and changing the data buffer are left to neighbouring logic.

Top module: `chien_locator`

## Requirements
- R1: After reset, `busy`, `done`, `uncorrectable`, `root_count` and `fix_en` are all zero.
- R2: A `start` pulse while `busy` is low begins a new search. From the next cycle `busy` is high and `done` is low. A `start` pulse while `busy` is high is ignored.
- R3: `done` rises exactly N clock edges after the edge that accepted `start`.
  - With `sector_big`=0: N = SECT_A_BYTES·8 + 13·T.
  - With `sector_big`=1: N = SECT_B_BYTES·8 + 14·T.
- R4: Position p (1 ≤ p ≤ N) is a root when the sum of sigma_k·alpha^(k·p), taken over k = 0..degree, equals zero in GF(2^m).
  - Coefficient k occupies `sigma[14k+13:14k]`.
  - alpha is the root of x^13+x^4+x^3+x+1 for m=13, and of x^14+x^10+x^6+x+1 for m=14.
  - Coefficients with k > degree have no effect. Bit 13 of each coefficient is ignored for m=13.
- R5: Roots are stored in ascending order. Entry i sits at `err_pos[PW·i +: PW]`. `root_count` gives the number of roots stored.
- R6: When `done` is high, `uncorrectable` is low exactly when the number of roots found is at most T and equals `degree`.
- R7: When more than T roots exist, `root_count` stays at T, the first T roots are kept, and `uncorrectable` is set.
- R8: For entry i holding position p, `fix_byte` entry i is (p−1)/8 and `fix_bit` entry i is (p−1) mod 8.
- R9: `fix_en[i]` is high only when all of these hold:
  - `done` is high and `uncorrectable` is low;
  - i < `root_count`;
  - the byte index is below the sector byte count plus `spare_bytes`.
  Positions past that limit are not corrected.
- R10: While `done` is high and no new search is started, `done`, `root_count`, `uncorrectable` and the lists hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin a search (accepted when not busy) |
| sector_big | input | 1 | 0: small sector with m=13; 1: large sector with m=14 |
| degree | input | CW | Declared degree of sigma |
| sigma | input | (T+1)·14 | Sigma coefficients, 14 bits each, k=0 in the low bits |
| spare_bytes | input | 8 | Bytes past the sector data that may still be corrected |
| busy | output | 1 | Search in progress |
| done | output | 1 | Search finished, results valid |
| root_count | output | CW | Number of roots stored |
| uncorrectable | output | 1 | Root count disagrees with degree, or more than T roots |
| err_pos | output | T·PW | 1-based root positions |
| fix_byte | output | T·BW | Byte index of each position |
| fix_bit | output | T·3 | Bit index of each position |
| fix_en | output | T | Entry is to be applied to the buffer |

## Verification
A bad power register in one term stepper gives a wrong evaluation at every position after the fault. This shows up as a missing root or a spurious root, so `root_count`, `uncorrectable` and the position list are all wrong when `done` rises. A position counter off by one shifts every reported position and moves the done edge by one cycle. Both are visible on the first completed search. A fault in the root list or the fix mapping only shows on `err_pos`, `fix_byte` or `fix_en` at `done`. The bench therefore compares every entry against positions that it picks itself and turns into sigma with its own field arithmetic.

// File: rtl/chien_pkg.sv
package chien_pkg;

    localparam int GF_W = 14;
    localparam logic [GF_W:0] POLY13 = 15'h201B;
    localparam logic [GF_W:0] POLY14 = 15'h4443;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_RUN  = 2'd1,
        ST_DONE = 2'd2
    } srch_state_e;

    typedef struct packed {
        logic       big;
        logic [7:0] spare;
    } srch_cfg_t;

    function automatic logic [GF_W-1:0] gf_xtime(input logic [GF_W-1:0] v, input logic big);
        logic [GF_W:0] w;
        w = {v, 1'b0};
        if (big) begin
            if (w[GF_W]) w = w ^ POLY14;
        end else begin
            if (w[GF_W-1]) w = w ^ POLY13;
        end
        return w[GF_W-1:0];
    endfunction

    function automatic logic [GF_W-1:0] gf_mul(input logic [GF_W-1:0] a,
                                               input logic [GF_W-1:0] b,
                                               input logic big);
        logic [GF_W-1:0] acc;
        acc = '0;
        for (int i = GF_W - 1; i >= 0; i--) begin
            acc = gf_xtime(acc, big);
            if (b[i]) acc = acc ^ a;
        end
        return acc;
    endfunction

    function automatic logic [GF_W-1:0] gf_alpha_pow(input int k, input logic big);
        logic [GF_W-1:0] v;
        v = 14'd1;
        for (int i = 0; i < k; i++) v = gf_xtime(v, big);
        return v;
    endfunction

endpackage

// File: rtl/chien_term.sv
module chien_term
    import chien_pkg::*;
#(
    parameter int K = 0
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            load,
    input  logic            step,
    input  logic            big,
    input  logic            active,
    input  logic [GF_W-1:0] coef,
    output logic [GF_W-1:0] term
);
    localparam logic [GF_W-1:0] STEP13 = gf_alpha_pow(K, 1'b0);
    localparam logic [GF_W-1:0] STEP14 = gf_alpha_pow(K, 1'b1);

    logic [GF_W-1:0] mult;
    logic [GF_W-1:0] coef_m;

    assign mult   = big ? STEP14 : STEP13;
    assign coef_m = big ? coef : {1'b0, coef[GF_W-2:0]};

    always_ff @(posedge clk) begin
        if (rst) begin
            term <= '0;
        end else if (load) begin
            term <= active ? gf_mul(coef_m, mult, big) : '0;
        end else if (step) begin
            term <= gf_mul(term, mult, big);
        end
    end
endmodule

// File: rtl/chien_root_list.sv
module chien_root_list #(
    parameter int T  = 8,
    parameter int PW = 14,
    parameter int CW = 4
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            clear,
    input  logic            hit,
    input  logic [PW-1:0]   pos,
    output logic [T*PW-1:0] list_flat,
    output logic [CW-1:0]   count,
    output logic            ovf
);
    logic [PW-1:0] lst [T];

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            count <= '0;
            ovf   <= 1'b0;
            for (int i = 0; i < T; i++) lst[i] <= '0;
        end else if (hit) begin
            if (count == CW'(T)) begin
                ovf <= 1'b1;
            end else begin
                lst[count] <= pos;
                count      <= count + 1'b1;
            end
        end
    end

    for (genvar g = 0; g < T; g++) begin : g_flat
        assign list_flat[g*PW +: PW] = lst[g];
    end
endmodule

// File: rtl/chien_fix_map.sv
module chien_fix_map
    import chien_pkg::*;
#(
    parameter int T            = 8,
    parameter int PW           = 14,
    parameter int BW           = 11,
    parameter int CW           = 4,
    parameter int SECT_A_BYTES = 512,
    parameter int SECT_B_BYTES = 1024
) (
    input  logic            valid,
    input  srch_cfg_t       cfg,
    input  logic [CW-1:0]   count,
    input  logic [T*PW-1:0] list_flat,
    output logic [T*BW-1:0] byte_flat,
    output logic [T*3-1:0]  bit_flat,
    output logic [T-1:0]    en
);
    int limit;
    assign limit = (cfg.big ? SECT_B_BYTES : SECT_A_BYTES) + int'(cfg.spare);

    for (genvar g = 0; g < T; g++) begin : g_ent
        logic [PW-1:0] pm1;
        logic [BW-1:0] byt;
        assign pm1 = list_flat[g*PW +: PW] - 1'b1;
        assign byt = BW'(pm1 >> 3);
        assign byte_flat[g*BW +: BW] = byt;
        assign bit_flat[g*3 +: 3]    = pm1[2:0];
        assign en[g] = valid && (CW'(g) < count) && (int'(byt) < limit);
    end
endmodule

// File: rtl/chien_locator.sv
module chien_locator
    import chien_pkg::*;
#(
    parameter int T            = 8,
    parameter int SECT_A_BYTES = 512,
    parameter int SECT_B_BYTES = 1024,
    localparam int NA   = SECT_A_BYTES * 8 + 13 * T,
    localparam int NB   = SECT_B_BYTES * 8 + 14 * T,
    localparam int NMAX = (NB > NA) ? NB : NA,
    localparam int PW   = $clog2(NMAX + 1),
    localparam int BW   = $clog2(NMAX / 8 + 1),
    localparam int CW   = $clog2(T + 1),
    localparam int SW   = (T + 1) * GF_W
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            start,
    input  logic            sector_big,
    input  logic [CW-1:0]   degree,
    input  logic [SW-1:0]   sigma,
    input  logic [7:0]      spare_bytes,
    output logic            busy,
    output logic            done,
    output logic [CW-1:0]   root_count,
    output logic            uncorrectable,
    output logic [T*PW-1:0] err_pos,
    output logic [T*BW-1:0] fix_byte,
    output logic [T*3-1:0]  fix_bit,
    output logic [T-1:0]    fix_en
);
    srch_state_e     state;
    srch_cfg_t       cfg_q;
    logic [CW-1:0]   deg_q;
    logic [PW-1:0]   pos_q;
    logic [PW-1:0]   n_len;
    logic            go, step, hit, ovf;
    logic [GF_W-1:0] terms [T+1];
    logic [GF_W-1:0] sum;

    assign go    = start && (state != ST_RUN);
    assign n_len = cfg_q.big ? PW'(NB) : PW'(NA);
    assign step  = (state == ST_RUN) && (pos_q != n_len);

    for (genvar k = 0; k <= T; k++) begin : g_term
        chien_term #(.K(k)) i_term (
            .clk    (clk),
            .rst    (rst),
            .load   (go),
            .step   (step),
            .big    (go ? sector_big : cfg_q.big),
            .active (CW'(k) <= degree),
            .coef   (sigma[k*GF_W +: GF_W]),
            .term   (terms[k])
        );
    end

    always_comb begin
        sum = '0;
        for (int k = 0; k <= T; k++) sum = sum ^ terms[k];
    end

    assign hit = (state == ST_RUN) && (sum == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_IDLE;
            cfg_q <= '0;
            deg_q <= '0;
            pos_q <= '0;
        end else if (go) begin
            state     <= ST_RUN;
            cfg_q.big <= sector_big;
            cfg_q.spare <= spare_bytes;
            deg_q     <= degree;
            pos_q     <= PW'(1);
        end else if (state == ST_RUN) begin
            if (pos_q == n_len) state <= ST_DONE;
            else                pos_q <= pos_q + 1'b1;
        end
    end

    chien_root_list #(.T(T), .PW(PW), .CW(CW)) i_list (
        .clk       (clk),
        .rst       (rst),
        .clear     (go),
        .hit       (hit),
        .pos       (pos_q),
        .list_flat (err_pos),
        .count     (root_count),
        .ovf       (ovf)
    );

    assign busy          = (state == ST_RUN);
    assign done          = (state == ST_DONE);
    assign uncorrectable = done && (ovf || (root_count != deg_q));

    chien_fix_map #(
        .T(T), .PW(PW), .BW(BW), .CW(CW),
        .SECT_A_BYTES(SECT_A_BYTES), .SECT_B_BYTES(SECT_B_BYTES)
    ) i_map (
        .valid     (done && !uncorrectable),
        .cfg       (cfg_q),
        .count     (root_count),
        .list_flat (err_pos),
        .byte_flat (fix_byte),
        .bit_flat  (fix_bit),
        .en        (fix_en)
    );
endmodule

// File: rtl/chien_locator_chk.sv
module chien_locator_chk #(
    parameter int T            = 8,
    parameter int SECT_A_BYTES = 512,
    parameter int SECT_B_BYTES = 1024,
    parameter int CW           = 4
) (
    input logic          clk,
    input logic          rst,
    input logic          start,
    input logic          sector_big,
    input logic [CW-1:0] degree,
    input logic          busy,
    input logic          done,
    input logic [CW-1:0] root_count,
    input logic          uncorrectable,
    input logic [T-1:0]  fix_en
);
    logic [CW-1:0] deg_l;
    logic          big_l;
    int            run_cnt;
    int            exp_len;

    assign exp_len = big_l ? SECT_B_BYTES * 8 + 14 * T : SECT_A_BYTES * 8 + 13 * T;

    always_ff @(posedge clk) begin
        if (rst) begin
            deg_l   <= '0;
            big_l   <= 1'b0;
            run_cnt <= 0;
        end else if (start && !busy) begin
            deg_l   <= degree;
            big_l   <= sector_big;
            run_cnt <= 0;
        end else if (busy) begin
            run_cnt <= run_cnt + 1;
        end
    end

    p_start_begins_r2: assert property (@(posedge clk) disable iff (rst)
        start && !busy |=> busy && !done);

    p_busy_done_mutex_r2: assert property (@(posedge clk) disable iff (rst)
        !(busy && done));

    p_length_r3: assert property (@(posedge clk) disable iff (rst)
        $rose(done) |-> run_cnt == exp_len);

    p_count_cap_r7: assert property (@(posedge clk) disable iff (rst)
        int'(root_count) <= T);

    p_ok_matches_degree_r6: assert property (@(posedge clk) disable iff (rst)
        done && !uncorrectable |-> root_count == deg_l);

    p_fix_gate_r9: assert property (@(posedge clk) disable iff (rst)
        fix_en != '0 |-> done && !uncorrectable);

    p_hold_r10: assert property (@(posedge clk) disable iff (rst)
        done && !start |=> done && $stable(root_count) && $stable(uncorrectable));
endmodule

bind chien_locator chien_locator_chk #(
    .T(T), .SECT_A_BYTES(SECT_A_BYTES), .SECT_B_BYTES(SECT_B_BYTES), .CW(CW)
) i_chk (
    .clk           (clk),
    .rst           (rst),
    .start         (start),
    .sector_big    (sector_big),
    .degree        (degree),
    .busy          (busy),
    .done          (done),
    .root_count    (root_count),
    .uncorrectable (uncorrectable),
    .fix_en        (fix_en)
);

// File: tb/test_chien_locator.sv
module test_chien_locator;
    localparam int T    = 4;
    localparam int SA   = 16;
    localparam int SB   = 32;
    localparam int NA   = SA * 8 + 13 * T;
    localparam int NB   = SB * 8 + 14 * T;
    localparam int PW   = $clog2(NB + 1);
    localparam int BW   = $clog2(NB / 8 + 1);
    localparam int CW   = $clog2(T + 1);
    localparam int SW   = (T + 1) * 14;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            start = 1'b0;
    logic            sector_big = 1'b0;
    logic [CW-1:0]   degree = '0;
    logic [SW-1:0]   sigma = '0;
    logic [7:0]      spare_bytes = '0;
    logic            busy, done, uncorrectable;
    logic [CW-1:0]   root_count;
    logic [T*PW-1:0] err_pos;
    logic [T*BW-1:0] fix_byte;
    logic [T*3-1:0]  fix_bit;
    logic [T-1:0]    fix_en;

    int total = 0;
    int bad   = 0;

    int roots [8];
    int nroots;
    int exp_list [8];
    int exp_cnt;
    bit exp_unc;

    always #2.5 clk = ~clk;

    chien_locator #(.T(T), .SECT_A_BYTES(SA), .SECT_B_BYTES(SB)) i_chien_locator (
        .clk(clk), .rst(rst), .start(start), .sector_big(sector_big),
        .degree(degree), .sigma(sigma), .spare_bytes(spare_bytes),
        .busy(busy), .done(done), .root_count(root_count),
        .uncorrectable(uncorrectable), .err_pos(err_pos), .fix_byte(fix_byte),
        .fix_bit(fix_bit), .fix_en(fix_en)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int ref_mul(input int a, input int b, input bit big);
        longint prod = 0;
        int m = big ? 14 : 13;
        longint poly = big ? 64'h4443 : 64'h201B;
        for (int i = 0; i < 14; i++) if ((b >> i) & 1) prod ^= longint'(a) << i;
        for (int bt = 27; bt >= m; bt--) if ((prod >> bt) & 1) prod ^= poly << (bt - m);
        return int'(prod);
    endfunction

    function automatic int ref_apow(input int e, input bit big);
        int v = 1;
        for (int i = 0; i < e; i++) v = ref_mul(v, 2, big);
        return v;
    endfunction

    // sigma = product of (x + alpha^r) over the chosen roots
    function automatic logic [SW-1:0] build_sigma(input bit big);
        int c [T+1];
        int nc [T+1];
        logic [SW-1:0] s;
        for (int k = 0; k <= T; k++) c[k] = 0;
        c[0] = 1;
        for (int r = 0; r < nroots; r++) begin
            int ar = ref_apow(roots[r], big);
            for (int k = 0; k <= T; k++) begin
                nc[k] = ref_mul(c[k], ar, big);
                if (k > 0) nc[k] ^= c[k-1];
            end
            for (int k = 0; k <= T; k++) c[k] = nc[k];
        end
        s = '0;
        for (int k = 0; k <= T; k++) s[k*14 +: 14] = 14'(c[k]);
        return s;
    endfunction

    function automatic void make_expect(input int n, input int deg);
        int tmp [8];
        int nf = 0;
        for (int i = 0; i < nroots; i++) if (roots[i] >= 1 && roots[i] <= n) begin
            tmp[nf] = roots[i];
            nf++;
        end
        for (int i = 0; i < nf; i++)
            for (int j = 0; j + 1 < nf - i; j++)
                if (tmp[j] > tmp[j+1]) begin
                    int t2 = tmp[j]; tmp[j] = tmp[j+1]; tmp[j+1] = t2;
                end
        exp_cnt = (nf > T) ? T : nf;
        for (int i = 0; i < exp_cnt; i++) exp_list[i] = tmp[i];
        exp_unc = (nf > T) || (nf != deg);
    endfunction

    task automatic run_search(input logic [SW-1:0] sg, input int deg, input bit big,
                              input int spare, input bit poke, input string tag);
        int n = 0;
        int len = big ? NB : NA;
        int lim = (big ? SB : SA) + spare;
        @(negedge clk);
        sigma = sg; degree = CW'(deg); sector_big = big; spare_bytes = 8'(spare);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy && !done, {"R2 busy after start ", tag}, busy, 1);
        while (!done && n < 2000) begin
            @(negedge clk);
            n++;
            if (poke && n == 20) start = 1'b1;
            if (poke && n == 21) start = 1'b0;
        end
        chk(n == len, {"R3 search length ", tag}, n, len);
        chk(root_count == CW'(exp_cnt), {"R5 root count ", tag}, root_count, exp_cnt);
        chk(uncorrectable == exp_unc, {"R6 verdict ", tag}, uncorrectable, exp_unc);
        for (int i = 0; i < exp_cnt; i++) begin
            int p  = int'(err_pos[i*PW +: PW]);
            int eb = (exp_list[i] - 1) / 8;
            bit ee = !exp_unc && (eb < lim);
            chk(p == exp_list[i], {"R4 position ", tag}, p, exp_list[i]);
            chk(int'(fix_byte[i*BW +: BW]) == eb, {"R8 byte index ", tag},
                fix_byte[i*BW +: BW], eb);
            chk(int'(fix_bit[i*3 +: 3]) == (exp_list[i] - 1) % 8, {"R8 bit index ", tag},
                fix_bit[i*3 +: 3], (exp_list[i] - 1) % 8);
            chk(fix_en[i] == ee, {"R9 fix enable ", tag}, fix_en[i], ee);
        end
        for (int i = exp_cnt; i < T; i++)
            chk(!fix_en[i], {"R9 unused entry ", tag}, fix_en[i], 0);
    endtask

    task automatic directed(input int a0, input int a1, input int a2, input int a3,
                            input int cnt, input int deg, input bit big, input int spare,
                            input string tag);
        logic [SW-1:0] s;
        roots[0] = a0; roots[1] = a1; roots[2] = a2; roots[3] = a3;
        nroots = cnt;
        s = build_sigma(big);
        make_expect(big ? NB : NA, deg);
        run_search(s, deg, big, spare, 1'b0, tag);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        logic [SW-1:0] s;
        void'($urandom(32'd4711));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        chk(!busy && !done && !uncorrectable && root_count == 0 && fix_en == 0,
            "R1 reset outputs", {busy, done, uncorrectable}, 0);

        directed(0, 0, 0, 0, 0, 0, 1'b0, 0, "no errors small");
        directed(5, 260, 300, 0, 3, 3, 1'b1, 0, "big parity spare0");
        directed(5, 260, 300, 0, 3, 3, 1'b1, 8, "big parity spare8");
        directed(10, 50, 200, 0, 3, 3, 1'b0, 0, "root past length");
        directed(1, 180, 0, 0, 2, 2, 1'b0, 0, "edge positions");
        directed(3, 77, 128, 129, 4, 4, 1'b0, 0, "full capacity");
        directed(9, 31, 0, 0, 2, 3, 1'b1, 0, "degree mismatch");

        // R4 coefficient above degree has no effect
        roots[0] = 7; roots[1] = 100; nroots = 2;
        s = build_sigma(1'b0);
        s[4*14 +: 14] = 14'h1234;
        s[0*14 + 13] = 1'b1;
        make_expect(NA, 2);
        run_search(s, 2, 1'b0, 0, 1'b0, "R4 masked high coef");

        // R7 overflow: zero polynomial vanishes everywhere
        nroots = 0;
        exp_cnt = T; exp_unc = 1'b1;
        for (int i = 0; i < T; i++) exp_list[i] = i + 1;
        run_search('0, 0, 1'b0, 0, 1'b0, "R7 overflow");

        // R2 start during search ignored
        roots[0] = 40; roots[1] = 90; nroots = 2;
        s = build_sigma(1'b1);
        make_expect(NB, 2);
        run_search(s, 2, 1'b1, 0, 1'b1, "R2 start while busy");

        // R10 results hold
        repeat (10) @(negedge clk);
        chk(done && root_count == CW'(exp_cnt) && !uncorrectable,
            "R10 results held", root_count, exp_cnt);

        // random cases
        for (int r = 0; r < 8; r++) begin
            bit big = 1'($urandom_range(0, 1));
            int n = big ? NB : NA;
            int deg = int'($urandom_range(0, T));
            nroots = deg;
            for (int i = 0; i < deg; i++) begin
                bit fresh;
                do begin
                    roots[i] = int'($urandom_range(1, n));
                    fresh = 1'b1;
                    for (int j = 0; j < i; j++) if (roots[j] == roots[i]) fresh = 1'b0;
                end while (!fresh);
            end
            s = build_sigma(big);
            make_expect(n, deg);
            run_search(s, deg, big, int'($urandom_range(0, 8)), 1'b0, "random");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule